// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time and the calendar date in packed-BCD registers. A fast sub-second strobe (`sub_tick`) is counted by an internal phase divider. Each time `TICKS_PER_SEC` strobes have been seen, the seconds advance, and the carry ripples through minutes, hours, weekday, day of month, month and the two-digit year within the same clock cycle. The hour register works in one of two forms, chosen by `hour24`. One is plain 24-hour BCD. The other is a 12-hour form with a PM flag, in which both midnight and noon read as 12. A century flag in the month register flips whenever the year wraps.

A host can overwrite any register at any time through a single-cycle write port that carries an index and a data byte. All seven registers are visible in parallel at all times. Two one-cycle strobes mark each advance of the seconds and each minute boundary, so alarm or interrupt logic can compare the time only when it changes.

Top module: `bcd_calendar`

## Requirements
- R1: After a synchronous active-low reset, seconds, minutes, hours, weekday and year read 0x00, day of month and month read 0x01, and both strobes are low.
- R2: The seconds register advances by one BCD step once per `TICKS_PER_SEC` (default 4) pulses of `sub_tick`. Fewer pulses leave it unchanged. Seconds and minutes each wrap from 0x59 to 0x00 and carry into the next register.
- R3: With `hour24`=1, the hour counts in BCD from 0x00 to 0x23. From 0x23 it wraps to 0x00 and advances the day.
- R4: With `hour24`=0, hour bits 4:0 hold BCD 01..12 and bit 5 is the PM flag. 0x11 (11 AM) goes to 0x32 (12 PM) with no day advance. 0x12 and 0x32 go to 0x01 and 0x21. 0x31 (11 PM) goes to 0x12 (12 AM) and advances the day.
- R5: The weekday sits in bits 2:0, counts 0 to 6 and wraps to 0. It advances with each day carry.
- R6: The day of month wraps to 0x01 once it reaches the month length, and the month then advances. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R7: The month (bits 4:0) wraps from 0x12 to 0x01 and advances the year. The year wraps from 0x99 to 0x00.
- R8: Month bit 7 is a century flag. It toggles when the year wraps from 0x99 to 0x00 and is otherwise preserved.
- R9: `sec_pulse` is high for the one cycle in which a new seconds value first appears. `min_pulse` is high in that same cycle only when the seconds went from 0x59 to 0x00.
- R10: A write to the seconds register restarts the sub-second phase, so a full `TICKS_PER_SEC` further pulses are needed before the next advance.
- R11: In a cycle with `wr_en` high, no register increments and that cycle's `sub_tick` is not counted. The written value wins and no strobe follows.
- R12: Write indices are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Data is masked to 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x9F and 0xFF respectively. Index 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_tick | input | 1 | Sub-second strobe, one cycle per pulse |
| hour24 | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour with PM flag |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data byte |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD (bit 5 PM in 12-hour mode) |
| wday_bcd | output | 8 | Weekday 0..6 |
| mday_bcd | output | 8 | Day of month, BCD |
| month_bcd | output | 8 | Month BCD in bits 4:0, century flag in bit 7 |
| year_bcd | output | 8 | Two-digit year, BCD |
| sec_pulse | output | 1 | One-cycle strobe on each seconds advance |
| min_pulse | output | 1 | One-cycle strobe when seconds wrap to 00 |

## Verification
A host write and the completion of a second can land in the same cycle. This happens when the last `sub_tick` of a second is presented together with `wr_en`. The bench provokes it twice. Once it writes the seconds register, and the written value must stand, no strobe may appear, and the next advance must need a full new count of sub-ticks. Once it writes the minutes register, and the seconds must hold and then advance on the very next sub-tick, because the colliding pulse was not counted.

// File: rtl/cal_pkg.sv
// Package: shared constants and BCD helpers for the calendar counter.
// Assumes all stored values are valid packed BCD unless a host wrote otherwise.
package cal_pkg;

    localparam int REG_W  = 8;
    localparam int IDX_W  = 3;
    localparam int N_REGS = 7;

    // Register indices on the write port
    localparam logic [IDX_W-1:0] IDX_SEC  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_MIN  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_HOUR = 3'd2;
    localparam logic [IDX_W-1:0] IDX_WDAY = 3'd3;
    localparam logic [IDX_W-1:0] IDX_MDAY = 3'd4;
    localparam logic [IDX_W-1:0] IDX_MON  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_YEAR = 3'd6;

    // Field masks applied on writes
    localparam logic [REG_W-1:0] MASK_SEC  = 8'h7F;
    localparam logic [REG_W-1:0] MASK_MIN  = 8'h7F;
    localparam logic [REG_W-1:0] MASK_HOUR = 8'h3F;
    localparam logic [REG_W-1:0] MASK_WDAY = 8'h07;
    localparam logic [REG_W-1:0] MASK_MDAY = 8'h3F;
    localparam logic [REG_W-1:0] MASK_MON  = 8'h9F;
    localparam logic [REG_W-1:0] MASK_YEAR = 8'hFF;
    localparam logic [REG_W-1:0] MON_DIGITS = 8'h1F;

    // One BCD step up; no wrap handling, callers decide the wrap point
    function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
        if (v[3:0] >= 4'd9)
            bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else
            bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A two-digit BCD year is a leap year when its value divides by 4
    function automatic logic leap_year(input logic [REG_W-1:0] y);
        int bin;
        bin = int'(y[7:4]) * 10 + int'(y[3:0]);
        leap_year = (bin % 4) == 0;
    endfunction

    // Last valid day (BCD) of a BCD month
    function automatic logic [REG_W-1:0] month_len(input logic [REG_W-1:0] m,
                                                   input logic leap);
        case (m)
            8'h02:                      month_len = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
            default:                    month_len = 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_subsec.sv
// Module: sub-second phase divider.
// Counts sub_tick pulses and emits sec_tick on the last pulse of each second.
// Assumes: a write cycle (hold) ignores sub_tick; clear restarts the phase.
module cal_subsec #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic hold,
    input  logic clear,
    output logic sec_tick
);
    localparam int PH_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);

    logic [PH_W-1:0] phase;
    logic            at_last;

    assign at_last  = (phase == PH_LAST);
    assign sec_tick = sub_tick && !hold && at_last;

    // Phase register: restart on clear, count unheld sub-ticks otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (clear)
            phase <= '0;
        else if (sub_tick && !hold)
            phase <= at_last ? '0 : phase + 1'b1;
    end

endmodule

// File: rtl/cal_wrap_cnt.sv
// Module: generic BCD counter with a wrap value and a masked host write.
// Carry is raised combinationally when an increment hits the top value.
// Assumes inc and wr are never both high (the divider holds during writes).
module cal_wrap_cnt
    import cal_pkg::*;
#(
    parameter logic [REG_W-1:0] MASK = 8'h7F,
    parameter logic [REG_W-1:0] RST  = 8'h00,
    parameter logic [REG_W-1:0] TOP  = 8'h59,
    parameter logic [REG_W-1:0] BOT  = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] q,
    output logic             carry
);
    logic at_top;

    assign at_top = (q >= TOP);
    assign carry  = inc && at_top;

    // Value register: write wins, else step or wrap on inc
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else if (wr)
            q <= wr_data & MASK;
        else if (inc)
            q <= at_top ? BOT : bcd_inc(q);
    end

endmodule

// File: rtl/cal_hour.sv
// Module: hour register in 24-hour BCD or 12-hour BCD with PM flag (bit 5).
// In 12-hour form midnight and noon both read 12; day carry is 11 PM -> 12 AM.
// Assumes the mode input is steady; switching modes does not convert the value.
module cal_hour
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hour24,
    input  logic             inc,
    input  logic             wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] q,
    output logic             day_carry
);
    logic [REG_W-1:0] nxt;
    logic             wrap_day;

    // Next hour and day-carry for one hour step in the selected form
    always_comb begin
        nxt      = q;
        wrap_day = 1'b0;
        if (hour24) begin
            if (q >= 8'h23) begin
                nxt      = 8'h00;
                wrap_day = 1'b1;
            end else begin
                nxt = bcd_inc(q);
            end
        end else begin
            if (q[4:0] == 5'h11) begin
                nxt      = {2'b00, ~q[5], 5'h12};
                wrap_day = q[5];
            end else if (q[4:0] >= 5'h12) begin
                nxt = {2'b00, q[5], 5'h01};
            end else begin
                nxt = {2'b00, q[5], 5'h00} | bcd_inc(q & 8'h1F);
            end
        end
    end

    assign day_carry = inc && wrap_day;

    // Hour register: write wins over a step
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 8'h00;
        else if (wr)
            q <= wr_data & MASK_HOUR;
        else if (inc)
            q <= nxt;
    end

endmodule

// File: rtl/cal_date.sv
// Module: weekday, day of month, month with century flag, and year.
// Month length follows the month and a divisible-by-4 leap rule on the year.
// Assumes day_inc is a single-cycle carry from the hour register.
module cal_date
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             day_inc,
    input  logic             wr_wday,
    input  logic             wr_mday,
    input  logic             wr_mon,
    input  logic             wr_year,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] wday_q,
    output logic [REG_W-1:0] mday_q,
    output logic [REG_W-1:0] mon_q,
    output logic [REG_W-1:0] year_q
);
    logic [REG_W-1:0] last_day;
    logic [REG_W-1:0] mon_nxt;
    logic             mday_wrap;
    logic             mon_inc;
    logic             mon_wrap;
    logic             year_carry;

    assign last_day  = month_len(mon_q & MON_DIGITS, leap_year(year_q));
    assign mday_wrap = (mday_q >= last_day);
    assign mon_inc   = day_inc && mday_wrap;
    assign mon_wrap  = ((mon_q & MON_DIGITS) >= 8'h12);

    // Next month: digits step or wrap, century flag flips on year wrap
    always_comb begin
        mon_nxt = {mon_q[7] ^ year_carry, 7'h00}
                | (mon_wrap ? 8'h01 : bcd_inc(mon_q & MON_DIGITS));
    end

    // Weekday register: 0..6 cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            wday_q <= 8'h00;
        else if (wr_wday)
            wday_q <= wr_data & MASK_WDAY;
        else if (day_inc)
            wday_q <= (wday_q >= 8'h06) ? 8'h00 : wday_q + 8'h01;
    end

    // Day-of-month register: wraps to 01 at the month length
    always_ff @(posedge clk) begin
        if (!rst_n)
            mday_q <= 8'h01;
        else if (wr_mday)
            mday_q <= wr_data & MASK_MDAY;
        else if (day_inc)
            mday_q <= mday_wrap ? 8'h01 : bcd_inc(mday_q);
    end

    // Month register: digits plus century flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            mon_q <= 8'h01;
        else if (wr_mon)
            mon_q <= wr_data & MASK_MON;
        else if (mon_inc)
            mon_q <= mon_nxt;
    end

    cal_wrap_cnt #(
        .MASK (MASK_YEAR),
        .RST  (8'h00),
        .TOP  (8'h99),
        .BOT  (8'h00)
    ) u_year (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (mon_inc && mon_wrap),
        .wr      (wr_year),
        .wr_data (wr_data),
        .q       (year_q),
        .carry   (year_carry)
    );

endmodule

// File: rtl/bcd_calendar.sv
// Module: top of the BCD calendar time counter.
// Divides sub_tick into seconds and ripples the carry through all registers
// in one cycle. Any write cycle freezes counting and the written value wins.
// Assumes sub_tick and the write port are synchronous to clk.
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_tick,
    input  logic             hour24,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] sec_bcd,
    output logic [REG_W-1:0] min_bcd,
    output logic [REG_W-1:0] hour_bcd,
    output logic [REG_W-1:0] wday_bcd,
    output logic [REG_W-1:0] mday_bcd,
    output logic [REG_W-1:0] month_bcd,
    output logic [REG_W-1:0] year_bcd,
    output logic             sec_pulse,
    output logic             min_pulse
);
    localparam int N_MS = 2;

    logic [N_REGS-1:0] wr_sel;
    logic [N_MS:0]     ms_chain;
    logic [REG_W-1:0]  ms_q [N_MS];
    logic              sec_tick;
    logic              day_inc;

    // Decode the write index into one select per register
    always_comb begin
        for (int k = 0; k < N_REGS; k++)
            wr_sel[k] = wr_en && (wr_idx == IDX_W'(k));
    end

    cal_subsec #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_subsec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_tick (sub_tick),
        .hold     (wr_en),
        .clear    (wr_sel[IDX_SEC]),
        .sec_tick (sec_tick)
    );

    assign ms_chain[0] = sec_tick;

    // Seconds then minutes: identical 00..59 counters chained by carry
    for (genvar g = 0; g < N_MS; g++) begin : g_ms
        cal_wrap_cnt #(
            .MASK (MASK_SEC),
            .RST  (8'h00),
            .TOP  (8'h59),
            .BOT  (8'h00)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (ms_chain[g]),
            .wr      (wr_sel[g]),
            .wr_data (wr_data),
            .q       (ms_q[g]),
            .carry   (ms_chain[g+1])
        );
    end

    assign sec_bcd = ms_q[0];
    assign min_bcd = ms_q[1];

    cal_hour u_hour (
        .clk       (clk),
        .rst_n     (rst_n),
        .hour24    (hour24),
        .inc       (ms_chain[N_MS]),
        .wr        (wr_sel[IDX_HOUR]),
        .wr_data   (wr_data),
        .q         (hour_bcd),
        .day_carry (day_inc)
    );

    cal_date u_date (
        .clk     (clk),
        .rst_n   (rst_n),
        .day_inc (day_inc),
        .wr_wday (wr_sel[IDX_WDAY]),
        .wr_mday (wr_sel[IDX_MDAY]),
        .wr_mon  (wr_sel[IDX_MON]),
        .wr_year (wr_sel[IDX_YEAR]),
        .wr_data (wr_data),
        .wday_q  (wday_bcd),
        .mday_q  (mday_bcd),
        .mon_q   (month_bcd),
        .year_q  (year_bcd)
    );

    // Strobes: registered alongside the counters they describe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_pulse <= 1'b0;
            min_pulse <= 1'b0;
        end else begin
            sec_pulse <= ms_chain[0];
            min_pulse <= ms_chain[1];
        end
    end

endmodule

// File: rtl/cal_checker.sv
// Module: temporal checks on the calendar counter ports, bound to the top.
// Assumes synchronous active-low reset; every property is disabled in reset.
module cal_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_idx,
    input logic [7:0] wr_data,
    input logic [7:0] sec_bcd,
    input logic [7:0] month_bcd,
    input logic [7:0] year_bcd,
    input logic       sec_pulse,
    input logic       min_pulse
);
    // R9
    sec_pulse_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (sec_bcd != $past(sec_bcd)));

    // R9
    min_pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        min_pulse |-> (sec_pulse && sec_bcd == 8'h00 && $past(sec_bcd) == 8'h59));

    // R11
    write_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> !sec_pulse);

    // R12
    sec_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_idx) == 3'd0)
            |-> (sec_bcd == ($past(wr_data) & 8'h7F)));

    // R8
    century_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $past(year_bcd) == 8'h99 && year_bcd == 8'h00)
            |-> (month_bcd[7] != $past(month_bcd[7])));

endmodule

bind bcd_calendar cal_checker u_cal_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sec_bcd   (sec_bcd),
    .month_bcd (month_bcd),
    .year_bcd  (year_bcd),
    .sec_pulse (sec_pulse),
    .min_pulse (min_pulse)
);

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table of start times, each advanced one second, then
// directed tests for reset, sub-tick phase, write collisions and masks.
module bcd_calendar_tb_top;

    localparam int TPS = 4;
    localparam int WD_CYCLES = 50000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sub_tick;
    logic       hour24;
    logic       wr_en;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;
    logic [7:0] sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, month_bcd, year_bcd;
    logic       sec_pulse, min_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bcd_calendar #(.TICKS_PER_SEC(TPS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .hour24    (hour24),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sec_bcd   (sec_bcd),
        .min_bcd   (min_bcd),
        .hour_bcd  (hour_bcd),
        .wday_bcd  (wday_bcd),
        .mday_bcd  (mday_bcd),
        .month_bcd (month_bcd),
        .year_bcd  (year_bcd),
        .sec_pulse (sec_pulse),
        .min_pulse (min_pulse)
    );

    typedef struct packed {
        logic       m24;
        logic [7:0] s, mi, h, wd, d, mo, y;
        logic [7:0] es, emi, eh, ewd, ed, emo, ey;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        // R2 plain second step
        '{1'b1, 8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00, 8'h01,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00, 4'd2},
        // R2 minute carry
        '{1'b1, 8'h59,8'h12,8'h05,8'h03,8'h10,8'h07,8'h45, 8'h00,8'h13,8'h05,8'h03,8'h10,8'h07,8'h45, 4'd2},
        // R3 hour step 09 -> 10
        '{1'b1, 8'h59,8'h59,8'h09,8'h03,8'h10,8'h07,8'h45, 8'h00,8'h00,8'h10,8'h03,8'h10,8'h07,8'h45, 4'd3},
        // R8 R7 full wrap, century set
        '{1'b1, 8'h59,8'h59,8'h23,8'h06,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h00,8'h01,8'h81,8'h00, 4'd8},
        // R6 Feb non-leap
        '{1'b1, 8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23, 4'd6},
        // R6 Feb leap, day 29 exists
        '{1'b1, 8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h24, 4'd6},
        // R6 Feb leap end
        '{1'b1, 8'h59,8'h59,8'h23,8'h03,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h24, 4'd6},
        // R6 30-day month end
        '{1'b1, 8'h59,8'h59,8'h23,8'h05,8'h30,8'h04,8'h10, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h05,8'h10, 4'd6},
        // R6 31-day month, day 31 exists
        '{1'b1, 8'h59,8'h59,8'h23,8'h05,8'h30,8'h01,8'h10, 8'h00,8'h00,8'h00,8'h06,8'h31,8'h01,8'h10, 4'd6},
        // R4 11 AM -> 12 PM
        '{1'b0, 8'h59,8'h59,8'h11,8'h01,8'h15,8'h06,8'h30, 8'h00,8'h00,8'h32,8'h01,8'h15,8'h06,8'h30, 4'd4},
        // R4 11 PM -> 12 AM with day advance
        '{1'b0, 8'h59,8'h59,8'h31,8'h04,8'h15,8'h06,8'h30, 8'h00,8'h00,8'h12,8'h05,8'h16,8'h06,8'h30, 4'd4},
        // R4 12 AM -> 1 AM
        '{1'b0, 8'h59,8'h59,8'h12,8'h04,8'h15,8'h06,8'h30, 8'h00,8'h00,8'h01,8'h04,8'h15,8'h06,8'h30, 4'd4},
        // R4 12 PM -> 1 PM
        '{1'b0, 8'h59,8'h59,8'h32,8'h04,8'h15,8'h06,8'h30, 8'h00,8'h00,8'h21,8'h04,8'h15,8'h06,8'h30, 4'd4},
        // R4 9 AM -> 10 AM
        '{1'b0, 8'h59,8'h59,8'h09,8'h04,8'h15,8'h06,8'h30, 8'h00,8'h00,8'h10,8'h04,8'h15,8'h06,8'h30, 4'd4},
        // R8 century flag cleared on second wrap
        '{1'b1, 8'h59,8'h59,8'h23,8'h00,8'h31,8'h92,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00, 4'd8},
        // R6 leap with odd tens digit (76)
        '{1'b1, 8'h59,8'h59,8'h23,8'h00,8'h28,8'h02,8'h76, 8'h00,8'h00,8'h00,8'h01,8'h29,8'h02,8'h76, 4'd6},
        // R6 year 00 is leap
        '{1'b1, 8'h59,8'h59,8'h23,8'h00,8'h28,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h29,8'h02,8'h00, 4'd6},
        // R5 weekday wrap 6 -> 0
        '{1'b1, 8'h59,8'h59,8'h23,8'h06,8'h30,8'h06,8'h11, 8'h00,8'h00,8'h00,8'h00,8'h01,8'h07,8'h11, 4'd5}
    };

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag,
                           input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y);
        chk(tag, "sec",   sec_bcd,   s);
        chk(tag, "min",   min_bcd,   mi);
        chk(tag, "hour",  hour_bcd,  h);
        chk(tag, "wday",  wday_bcd,  wd);
        chk(tag, "mday",  mday_bcd,  d);
        chk(tag, "month", month_bcd, mo);
        chk(tag, "year",  year_bcd,  y);
    endtask

    // One cycle of stimulus, applied at the falling edge
    task automatic cyc(input logic we, input logic [2:0] idx,
                       input logic [7:0] d, input logic st);
        @(negedge clk);
        wr_en = we; wr_idx = idx; wr_data = d; sub_tick = st;
    endtask

    // Return inputs to idle; outputs of the previous edge are then sampled
    task automatic settle();
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd0; wr_data = 8'h00; sub_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 3'd0, 8'h00, 1'b1);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; sub_tick = 1'b0; hour24 = 1'b1;
        wr_en = 1'b0; wr_idx = 3'd0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk_all("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        chk("R1", "sec_pulse", {7'd0, sec_pulse}, 8'h00);
        chk("R1", "min_pulse", {7'd0, min_pulse}, 8'h00);

        // R2 one pulse short of a second: no advance, then the last one advances
        ticks(TPS - 1); settle();
        chk("R2", "sec short", sec_bcd, 8'h00);
        ticks(1); settle();
        chk("R2", "sec full", sec_bcd, 8'h01);
        chk("R9", "sec_pulse", {7'd0, sec_pulse}, 8'h01);

        // Vector table: load, advance one second, compare
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); hour24 = VEC[i].m24;
            cyc(1'b1, 3'd0, VEC[i].s,  1'b0);
            cyc(1'b1, 3'd1, VEC[i].mi, 1'b0);
            cyc(1'b1, 3'd2, VEC[i].h,  1'b0);
            cyc(1'b1, 3'd3, VEC[i].wd, 1'b0);
            cyc(1'b1, 3'd4, VEC[i].d,  1'b0);
            cyc(1'b1, 3'd5, VEC[i].mo, 1'b0);
            cyc(1'b1, 3'd6, VEC[i].y,  1'b0);
            ticks(TPS); settle();
            chk_all($sformatf("R%0d row%0d", VEC[i].rq, i),
                    VEC[i].es, VEC[i].emi, VEC[i].eh, VEC[i].ewd,
                    VEC[i].ed, VEC[i].emo, VEC[i].ey);
            chk($sformatf("R9 row%0d", i), "sec_pulse", {7'd0, sec_pulse}, 8'h01);
            chk($sformatf("R9 row%0d", i), "min_pulse", {7'd0, min_pulse},
                {7'd0, VEC[i].s == 8'h59});
        end

        // R10 R11 seconds write collides with the completing sub-tick
        hour24 = 1'b1;
        cyc(1'b1, 3'd0, 8'h30, 1'b0);
        ticks(TPS - 1);
        cyc(1'b1, 3'd0, 8'h45, 1'b1);
        settle();
        chk("R11", "sec write wins", sec_bcd, 8'h45);
        chk("R11", "no sec_pulse", {7'd0, sec_pulse}, 8'h00);
        ticks(TPS - 1); settle();
        chk("R10", "phase restarted", sec_bcd, 8'h45);
        ticks(1); settle();
        chk("R10", "advance after full count", sec_bcd, 8'h46);

        // R11 minutes write collides: colliding sub-tick is not counted
        ticks(TPS - 1);
        cyc(1'b1, 3'd1, 8'h07, 1'b1);
        settle();
        chk("R11", "sec held", sec_bcd, 8'h46);
        chk("R11", "min written", min_bcd, 8'h07);
        chk("R11", "no sec_pulse", {7'd0, sec_pulse}, 8'h00);
        ticks(1); settle();
        chk("R11", "deferred advance", sec_bcd, 8'h47);

        // R12 write masks per index, then index 7 has no effect
        for (int k = 0; k < 7; k++) cyc(1'b1, 3'(k), 8'hFF, 1'b0);
        settle();
        chk_all("R12", 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h9F, 8'hFF);
        cyc(1'b1, 3'd7, 8'h00, 1'b0);
        settle();
        chk_all("R12 idx7", 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h9F, 8'hFF);

        summary();
        $finish;
    end

endmodule